// File: doc/BRIEF.md
# Serial Key Entry Port

This block takes a 64-bit secret key over a two-wire serial link, a key clock and a key data line. The whole block runs on a fast master clock. Both serial lines are slow enough to be synchronized into the master clock domain. The rising edges of the key clock are found there, and the key data line is sampled on those edges.

The level of the data line while the active-low reset is held picks the action taken after reset. A low level arms the port for a new key and erases whatever it holds. A high level leaves the stored key and its valid flag as they were. Once armed, the port lets a programmable settling interval pass, then accepts a 68-bit frame: a 4-bit header that must be zero, then the key with its most significant bit first. A frame with a bad header is discarded. The port then ignores the serial lines until the next arming reset.

The key goes only to an on-chip consumer through a parallel port with a valid flag. No path leads back to the serial pins, and the parallel port shows all zeros unless a complete frame has been accepted.

Top module: `keyport_loader`

## Requirements
- R1: When `key_dat_i` is low while `rst_n` is low, the port arms: `key_valid_o` goes low and `key_o` reads zero before the reset is released.
- R2: When `key_dat_i` is high while `rst_n` is low, the stored key and `key_valid_o` keep their values through the reset, and no load follows it.
- R3: An accepted frame is 68 bits in transmission order: 4 header bits, then 64 key bits. The first key bit lands in `key_o[63]` and the last in `key_o[0]`. `key_valid_o` stays low through the 67th bit and rises after the 68th.
- R4: If any of the 4 header bits is 1, the frame is rejected. `key_valid_o` stays low, and further key clock edges are ignored until the next arming reset.
- R5: After an arming reset is released, key clock edges are ignored for the first WAIT_CYCLES master clock cycles (default 120).
- R6: An armed port waits with no time limit for the frame to start.
- R7: `key_o` reads all zeros whenever `key_valid_o` is low. The block has no serial output.
- R8: Once `key_valid_o` is high, further key clock edges leave `key_o` unchanged.
- R9: Each bit is taken from `key_dat_i` at a rising edge of the key clock, after both lines have passed through the same synchronizer depth. Data that changes while the key clock is low is taken correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, sampled on the master clock |
| key_clk_i | input | 1 | Serial key clock, asynchronous to the master clock |
| key_dat_i | input | 1 | Serial key data; its level during reset selects arm or keep |
| key_o | output | KEY_W | Loaded key for the internal consumer, zero while not valid |
| key_valid_o | output | 1 | High once a full frame with a zero header has been loaded |

## Verification
The bench walks a single one through all 64 key positions and tries all 15 nonzero headers. A port that shifted in the wrong direction or miscounted bits would return a rotated key. One that skipped the header check would flag a rejected frame as valid. It sends key clock pulses during the settling interval, and a design that counted them would misalign the frame so that the valid flag never rises. It also issues keep resets after a good load and after a rejection, sends extra edges after a load, and holds an armed port idle for a long time. These catch a design that clears the key on every reset, lets trailing bits overwrite the key, or gives up waiting for a frame.

// File: rtl/keyport_pkg.sv
package keyport_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WAIT   = 3'd1,
      ST_LOAD   = 3'd2,
      ST_REJECT = 3'd3,
      ST_DONE   = 3'd4
   } kp_state_t;
endpackage

// File: rtl/keyport_sync.sv
module keyport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("keyport_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/keyport_edge.sv
module keyport_edge (
   input  logic clk,
   input  logic lvl,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk) begin
      prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/keyport_ctrl.sv
module keyport_ctrl
   import keyport_pkg::*;
#(
   parameter int HDR_W       = 4,
   parameter int FRAME_W     = 68,
   parameter int WAIT_CYCLES = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sdat,
   input  logic rise,
   output logic shift_o,
   output logic done_o,
   output logic arm_clr_o
);
   localparam int CNT_W  = $clog2(FRAME_W + 1);
   localparam int WCNT_W = $clog2(WAIT_CYCLES + 1);

   if (WAIT_CYCLES < 1) begin : g_bad_wait
      $error("keyport_ctrl: WAIT_CYCLES must be at least 1");
   end
   if (HDR_W < 1 || HDR_W >= FRAME_W) begin : g_bad_hdr
      $error("keyport_ctrl: HDR_W out of range");
   end

   kp_state_t          state_q;
   logic [CNT_W-1:0]   bcnt_q;
   logic [WCNT_W-1:0]  wcnt_q;
   logic               loading;
   logic               in_hdr;
   logic               hdr_bad;
   logic               last_bit;

   assign loading  = (state_q == ST_LOAD);
   assign in_hdr   = (bcnt_q < CNT_W'(HDR_W));
   assign last_bit = (bcnt_q == CNT_W'(FRAME_W - 1));
   assign hdr_bad  = rise & loading & in_hdr & sdat;

   assign shift_o   = rise & loading & ~in_hdr;
   assign done_o    = rise & loading & last_bit;
   assign arm_clr_o = ~rst_n & ~sdat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= sdat ? ST_IDLE : ST_WAIT;
         bcnt_q  <= '0;
         wcnt_q  <= '0;
      end else begin
         unique case (state_q)
            ST_WAIT: begin
               if (wcnt_q == WCNT_W'(WAIT_CYCLES - 1)) begin
                  state_q <= ST_LOAD;
               end else begin
                  wcnt_q <= wcnt_q + 1'b1;
               end
            end
            ST_LOAD: begin
               if (hdr_bad) begin
                  state_q <= ST_REJECT;
               end else if (rise) begin
                  if (last_bit) begin
                     state_q <= ST_DONE;
                  end
                  bcnt_q <= bcnt_q + 1'b1;
               end
            end
            ST_IDLE, ST_REJECT, ST_DONE: begin
               state_q <= state_q;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/keyport_store.sv
module keyport_store #(
   parameter int KEY_W            = 64,
   parameter bit HIDE_UNTIL_VALID = 1'b1
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             shift,
   input  logic             din,
   input  logic             done,
   output logic [KEY_W-1:0] key_o,
   output logic             valid_o
);
   if (KEY_W < 2) begin : g_bad_key
      $error("keyport_store: KEY_W must be at least 2");
   end

   logic [KEY_W-1:0] key_q;
   logic             valid_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         key_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         if (shift) begin
            key_q <= {key_q[KEY_W-2:0], din};
         end
         if (done) begin
            valid_q <= 1'b1;
         end
      end
   end

   if (HIDE_UNTIL_VALID) begin : g_gated
      assign key_o = valid_q ? key_q : '0;
   end else begin : g_open
      assign key_o = key_q;
   end

   assign valid_o = valid_q;
endmodule

// File: rtl/keyport_loader.sv
module keyport_loader #(
   parameter int KEY_W       = 64,
   parameter int HDR_W       = 4,
   parameter int WAIT_CYCLES = 120,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_clk_i,
   input  logic             key_dat_i,
   output logic [KEY_W-1:0] key_o,
   output logic             key_valid_o
);
   localparam int FRAME_W = KEY_W + HDR_W;

   logic kclk_s;
   logic kdat_s;
   logic kclk_rise;
   logic key_shift;
   logic key_done;
   logic arm_clr;

   keyport_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk  (clk),
      .din  (key_clk_i),
      .dout (kclk_s)
   );

   keyport_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk  (clk),
      .din  (key_dat_i),
      .dout (kdat_s)
   );

   keyport_edge u_edge (
      .clk  (clk),
      .lvl  (kclk_s),
      .rise (kclk_rise)
   );

   keyport_ctrl #(
      .HDR_W       (HDR_W),
      .FRAME_W     (FRAME_W),
      .WAIT_CYCLES (WAIT_CYCLES)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sdat      (kdat_s),
      .rise      (kclk_rise),
      .shift_o   (key_shift),
      .done_o    (key_done),
      .arm_clr_o (arm_clr)
   );

   keyport_store #(
      .KEY_W            (KEY_W),
      .HIDE_UNTIL_VALID (1'b1)
   ) u_store (
      .clk     (clk),
      .clr     (arm_clr),
      .shift   (key_shift),
      .din     (kdat_s),
      .done    (key_done),
      .key_o   (key_o),
      .valid_o (key_valid_o)
   );
endmodule

// File: rtl/keyport_loader_chk.sv
module keyport_loader_chk #(
   parameter int KEY_W       = 64,
   parameter int WAIT_CYCLES = 120
) (
   input logic             clk,
   input logic             rst_n,
   input logic             key_valid_o,
   input logic [KEY_W-1:0] key_o,
   input logic             kclk_rise,
   input logic             key_shift
);
   localparam int SW = $clog2(WAIT_CYCLES + 1);

   logic [SW-1:0] since_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= '0;
      end else if (since_q < SW'(WAIT_CYCLES)) begin
         since_q <= since_q + 1'b1;
      end
   end

   // R7: nothing of the key is visible while the flag is low
   p_key_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !key_valid_o |-> (key_o == '0));

   // R3: the flag only drops through reset
   p_valid_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |=> key_valid_o);

   // R3: the flag rises only after a detected key clock edge
   p_valid_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_valid_o) |-> $past(kclk_rise));

   // R8: a loaded key does not move
   p_key_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |=> $stable(key_o));

   // R5: no shifting inside the settling interval
   p_wait_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q < SW'(WAIT_CYCLES)) |-> !key_shift);
endmodule

bind keyport_loader keyport_loader_chk #(
   .KEY_W       (KEY_W),
   .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .key_valid_o (key_valid_o),
   .key_o       (key_o),
   .kclk_rise   (kclk_rise),
   .key_shift   (key_shift)
);

// File: tb/keyport_loader_tb_top.sv
module keyport_loader_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WAITC      = 120;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_clk_i = 1'b0;
   logic        key_dat_i = 1'b0;
   logic [63:0] key_o;
   logic        key_valid_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyport_loader #(
      .KEY_W(64), .HDR_W(4), .WAIT_CYCLES(WAITC), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .key_clk_i(key_clk_i), .key_dat_i(key_dat_i),
      .key_o(key_o), .key_valid_o(key_valid_o)
   );

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // arm=1: data low during reset; arm=0: data high (keep)
   task automatic do_reset(input bit arm, input bit check_arm);
      key_clk_i = 1'b0;
      key_dat_i = ~arm;
      rst_n = 1'b0;
      cycles(6);
      if (check_arm) begin
         check({63'd0, key_valid_o}, 64'd0, "R1 valid low in arming reset");
         check(key_o, 64'd0, "R1 key zero in arming reset");
      end
      rst_n = 1'b1;
      cycles(4);
      key_dat_i = 1'b0;
   endtask

   task automatic send_bit(input bit b);
      key_dat_i = b;
      key_clk_i = 1'b0;
      cycles(4);
      key_clk_i = 1'b1;
      cycles(4);
      key_clk_i = 1'b0;
   endtask

   task automatic send_frame(input logic [3:0] hdr, input logic [63:0] key);
      for (int i = 3; i >= 0; i--) send_bit(hdr[i]);
      for (int i = 63; i >= 0; i--) send_bit(key[i]);
      cycles(6);
   endtask

   task automatic arm_and_settle();
      do_reset(1'b1, 1'b0);
      cycles(WAITC);
   endtask

   initial begin
      logic [63:0] k;
      // R1: reset state after arming reset
      do_reset(1'b1, 1'b1);
      check({63'd0, key_valid_o}, 64'd0, "R1 valid low after release");
      check(key_o, 64'd0, "R7 key zero while invalid");
      cycles(WAITC);

      // R3: bit count boundary, valid only after the 68th bit
      k = 64'hC3A5_0F1E_9B27_6D48;
      for (int i = 3; i >= 0; i--) send_bit(1'b0);
      for (int i = 63; i >= 1; i--) send_bit(k[i]);
      cycles(8);
      check({63'd0, key_valid_o}, 64'd0, "R3 no valid after 67 bits");
      check(key_o, 64'd0, "R7 key hidden during load");
      send_bit(k[0]);
      cycles(6);
      check({63'd0, key_valid_o}, 64'd1, "R3 valid after 68 bits");
      check(key_o, k, "R3 key order");

      // R8: extra edges after load
      for (int i = 0; i < 10; i++) send_bit(i[0]);
      cycles(6);
      check(key_o, k, "R8 key unchanged by extra edges");
      check({63'd0, key_valid_o}, 64'd1, "R8 valid held");

      // R2: keep reset retains key, no load follows
      do_reset(1'b0, 1'b0);
      cycles(WAITC);
      check({63'd0, key_valid_o}, 64'd1, "R2 valid kept");
      check(key_o, k, "R2 key kept");
      send_frame(4'h0, 64'h1111_2222_3333_4444);
      check(key_o, k, "R2 no load after keep reset");

      // R1: arming reset clears
      do_reset(1'b1, 1'b1);

      // R5: edges during settling interval ignored
      cycles(20);
      send_bit(1'b1);
      cycles(60);
      send_bit(1'b1);
      cycles(WAITC);
      k = 64'h0123_4567_89AB_CDEF;
      send_frame(4'h0, k);
      check({63'd0, key_valid_o}, 64'd1, "R5 valid despite early edges");
      check(key_o, k, "R5 key despite early edges");

      // R6: long idle before frame
      do_reset(1'b1, 1'b0);
      cycles(3000);
      k = 64'hFEDC_BA98_7654_3210;
      send_frame(4'h0, k);
      check({63'd0, key_valid_o}, 64'd1, "R6 valid after long idle");
      check(key_o, k, "R6 key after long idle");

      // R3/R9: walking one across every key position
      for (int p = 0; p < 64; p++) begin
         arm_and_settle();
         k = 64'd1 << p;
         send_frame(4'h0, k);
         check(key_o, k, "R3 R9 walking one");
      end
      arm_and_settle();
      send_frame(4'h0, '1);
      check(key_o, '1, "R9 all ones key");

      // R4: every nonzero header rejected
      for (int h = 1; h < 16; h++) begin
         arm_and_settle();
         send_frame(h[3:0], 64'hA5A5_5A5A_A5A5_5A5A);
         check({63'd0, key_valid_o}, 64'd0, "R4 bad header rejected");
         check(key_o, 64'd0, "R4 key hidden after reject");
      end
      // R4: after reject, a later good frame is ignored
      send_frame(4'h0, 64'h5555_AAAA_5555_AAAA);
      check({63'd0, key_valid_o}, 64'd0, "R4 edges ignored after reject");
      // R2: keep reset after reject keeps invalid
      do_reset(1'b0, 1'b0);
      cycles(WAITC);
      send_frame(4'h0, 64'h5555_AAAA_5555_AAAA);
      check({63'd0, key_valid_o}, 64'd0, "R2 keep reset after reject");

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule